// File: doc/BRIEF.md
# Receive Frame Check Sequence Verifier and Trimmer

This block sits on a receive byte-lane packet stream once the preamble and start delimiter have already been removed. Each beat carries up to `BYTES` bytes. It has a valid strobe, an end-of-frame marker and a count of the bytes in use on that beat. While the frame streams through, the block runs the Ethernet CRC-32 over every byte. On the closing beat it sorts the frame into one of three classes: the trailing four bytes are a correct check sequence, a corrupted one, or a deliberately poisoned ("stomped") one. A stomped check sequence is the bitwise complement of the correct value.

The frame passes on to the user side. If the check sequence is to be removed, the block holds back one beat. This lets it move the end marker and byte count to the last payload byte, even when the four check bytes straddle two input beats. Frames of eight bytes or fewer always keep their check bytes. An error can be flagged on a sideband bit on the closing output beat. Two one-cycle status pulses, one for bad and one for stomped check sequences, feed external statistics logic.

Top module: `rxfcs_check_strip`

## Requirements
- R1: The CRC is the reflected CRC-32 with polynomial 0x04C11DB7. The register starts at all ones and the result is complemented. The check sequence is the last four bytes of the frame, least significant byte first. A frame whose check sequence matches leaves with `out_user_err` low and raises neither pulse.
- R2: With `strip_en` = 1, a frame longer than 8 bytes leaves without its last four bytes. `out_last` and `out_nbytes` mark the last payload byte, including when the check bytes span two input beats.
- R3: With `strip_en` = 0, every byte of every frame leaves unchanged and in order, check bytes included.
- R4: A frame of 8 bytes or fewer is never trimmed, whatever the value of `strip_en`.
- R5: With `ignore_fcs` = 0, a frame with a bad or stomped check sequence leaves with `out_user_err` = 1 on its `out_last` beat. `out_user_err` is 0 on every other beat.
- R6: With `ignore_fcs` = 1, `out_user_err` stays 0, but `bad_fcs_pulse` and `stomped_fcs_pulse` still fire.
- R7: A check sequence equal to the bitwise complement of the correct value raises `stomped_fcs_pulse` only. Any other mismatch raises `bad_fcs_pulse` only.
- R8: Each pulse is high for exactly one cycle, in the cycle after the clock edge that accepts the frame's closing input beat. Pulses for frames that close on consecutive cycles are back to back.
- R9: While `rst_n` is low, and just after it is released, `out_valid`, `out_last`, `out_user_err` and both pulses are 0.
- R10: `out_nbytes` ranges from 1 to `BYTES`. Byte lane 0 (`out_data[7:0]`) is the earliest byte, and lanes at or above `out_nbytes` read as zero. Every beat except a frame's last beat carries `BYTES` bytes.
- R11: Idle cycles (`in_valid` = 0) between the beats of a frame change neither the data nor the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strip_en | input | 1 | 1: remove the check bytes from frames longer than 8 bytes |
| ignore_fcs | input | 1 | 1: never raise the user error bit |
| in_valid | input | 1 | Input beat present |
| in_data | input | 8*BYTES | Input bytes, lane 0 earliest |
| in_nbytes | input | $clog2(BYTES+1) | Bytes used on this beat (1..BYTES) |
| in_last | input | 1 | Closing beat of the frame |
| out_valid | output | 1 | Output beat present |
| out_data | output | 8*BYTES | Output bytes, unused lanes zero |
| out_nbytes | output | $clog2(BYTES+1) | Bytes used on this output beat |
| out_last | output | 1 | Closing output beat |
| out_user_err | output | 1 | Frame failed its check (closing beat only) |
| bad_fcs_pulse | output | 1 | One-cycle pulse: corrupted check sequence |
| stomped_fcs_pulse | output | 1 | One-cycle pulse: complemented check sequence |

## Verification
The assertions assume the following about the input stream:
- Every beat that is not a frame's last beat is full.
- `in_nbytes` is never 0.
- `strip_en` and `ignore_fcs` move only while reset is held.

Under these assumptions, a trimmed closing beat of four bytes or fewer always finds an earlier beat of the same frame in the hold register. The directed tasks build frames only of this shape, and they change either setting only inside the reset task. Frame lengths are chosen so the closing beat carries 1, 2, 3, 4, 5 and 8 bytes, which places the check bytes in one beat or across two, and some frames have idle gaps between beats.

// File: rtl/rxfcs_pkg.sv
package rxfcs_pkg;

   localparam int unsigned FCS_BYTES = 4;
   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
   localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;
   // Register value left after a frame whose check bytes are correct.
   localparam logic [31:0] CRC_GOOD_RESIDUE = 32'hDEBB_20E3;
   // Register value left when the check bytes are the uncomplemented CRC.
   localparam logic [31:0] CRC_STOMP_RESIDUE = 32'h0000_0000;

   function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                 input logic [7:0] d);
      logic [31:0] c;
      c = c_in;
      for (int i = 0; i < 8; i++) begin
         c = (c >> 1) ^ (CRC_POLY_REFL & {32{c[0] ^ d[i]}});
      end
      return c;
   endfunction

endpackage

// File: rtl/rxfcs_crc_check.sv
module rxfcs_crc_check
   import rxfcs_pkg::*;
#(
   parameter int unsigned BYTES = 8,
   parameter int unsigned NB_W  = $clog2(BYTES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [8*BYTES-1:0] in_data,
   input  logic [NB_W-1:0]    in_nb,
   input  logic               in_last,
   output logic               verdict_err,
   output logic               bad_pulse,
   output logic               stomp_pulse
);

   logic [31:0] crc_q, crc_nx;
   logic        close_now, is_good, is_stomp;

   // Running CRC over the bytes in use on this beat.
   always_comb begin
      crc_nx = crc_q;
      for (int b = 0; b < BYTES; b++) begin
         if (NB_W'(b) < in_nb) crc_nx = crc_step_byte(crc_nx, in_data[8*b +: 8]);
      end
   end

   assign close_now   = in_valid && in_last;
   assign is_good     = (crc_nx == CRC_GOOD_RESIDUE);
   assign is_stomp    = (crc_nx == CRC_STOMP_RESIDUE);
   assign verdict_err = !is_good;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q       <= CRC_INIT;
         bad_pulse   <= 1'b0;
         stomp_pulse <= 1'b0;
      end else begin
         if (in_valid) crc_q <= in_last ? CRC_INIT : crc_nx;
         bad_pulse   <= close_now && !is_good && !is_stomp;
         stomp_pulse <= close_now && is_stomp;
      end
   end

   assert_one_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(bad_pulse && stomp_pulse));

   assert_pulse_after_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_pulse || stomp_pulse) |-> $past(in_valid && in_last));

endmodule

// File: rtl/rxfcs_realign.sv
module rxfcs_realign
   import rxfcs_pkg::*;
#(
   parameter int unsigned BYTES    = 8,
   parameter int unsigned NB_W     = $clog2(BYTES + 1),
   parameter int unsigned KEEP_LEN = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               strip_en,
   input  logic               in_valid,
   input  logic [8*BYTES-1:0] in_data,
   input  logic [NB_W-1:0]    in_nb,
   input  logic               in_last,
   input  logic               in_err,
   output logic               out_valid,
   output logic [8*BYTES-1:0] out_data,
   output logic [NB_W-1:0]    out_nb,
   output logic               out_last,
   output logic               out_err
);

   localparam int unsigned LEN_W = $clog2(KEEP_LEN + BYTES + 1) + 1;
   localparam logic [NB_W-1:0]  FCS_NB  = NB_W'(FCS_BYTES);
   localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(KEEP_LEN + 1);

   // Hold register: one beat kept back for realignment.
   logic               h_v, h_last, h_err;
   logic [8*BYTES-1:0] h_data;
   logic [NB_W-1:0]    h_nb;
   logic               nh_v, nh_last, nh_err;
   logic [8*BYTES-1:0] nh_data;
   logic [NB_W-1:0]    nh_nb;

   logic [LEN_W-1:0]   len_q, len_sum;
   logic               long_frame, do_strip, emit;
   logic               o_v, o_last, o_err;
   logic [NB_W-1:0]    o_nb;
   logic [8*BYTES-1:0] data_q;

   assign len_sum    = len_q + LEN_W'(in_nb);
   assign long_frame = (len_sum > LEN_W'(KEEP_LEN));
   assign do_strip   = strip_en && long_frame;
   assign emit       = h_v && (in_valid || h_last);

   always_comb begin
      o_v     = emit;
      o_nb    = h_nb;
      o_last  = h_last;
      o_err   = h_err;
      nh_v    = h_v && !emit;
      nh_data = h_data;
      nh_nb   = h_nb;
      nh_last = h_last;
      nh_err  = h_err;
      if (in_valid) begin
         if (!in_last || !do_strip || (in_nb > FCS_NB)) begin
            nh_v    = 1'b1;
            nh_data = in_data;
            nh_nb   = (in_last && do_strip) ? (in_nb - FCS_NB) : in_nb;
            nh_last = in_last;
            nh_err  = in_last && in_err;
         end else begin
            // Whole tail is check bytes: the held beat becomes the closing one.
            o_last = 1'b1;
            o_nb   = h_nb + in_nb - FCS_NB;
            o_err  = in_err;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h_v       <= 1'b0;
         h_last    <= 1'b0;
         h_err     <= 1'b0;
         h_nb      <= '0;
         h_data    <= '0;
         len_q     <= '0;
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         out_err   <= 1'b0;
         out_nb    <= '0;
         data_q    <= '0;
      end else begin
         h_v       <= nh_v;
         h_last    <= nh_last;
         h_err     <= nh_err;
         h_nb      <= nh_nb;
         h_data    <= nh_data;
         if (in_valid) len_q <= in_last ? '0 : (long_frame ? LEN_CAP : len_sum);
         out_valid <= o_v;
         out_last  <= o_v && o_last;
         out_err   <= o_v && o_err;
         out_nb    <= o_nb;
         data_q    <= h_data;
      end
   end

   // Unused output lanes read as zero.
   for (genvar l = 0; l < BYTES; l++) begin : g_lane
      assign out_data[8*l +: 8] = (NB_W'(l) < out_nb) ? data_q[8*l +: 8] : 8'h00;
   end

   assert_err_on_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err) |-> out_last);

   assert_nb_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_nb != '0) && (out_nb <= NB_W'(BYTES))));

   assert_full_mid_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |-> (out_nb == NB_W'(BYTES)));

   assert_tail_has_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last && do_strip && (in_nb <= FCS_NB)) |-> (h_v && !h_last));

endmodule

// File: rtl/rxfcs_check_strip.sv
module rxfcs_check_strip
   import rxfcs_pkg::*;
#(
   parameter int unsigned BYTES    = 8,
   parameter int unsigned KEEP_LEN = 8,
   localparam int unsigned NB_W    = $clog2(BYTES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               strip_en,
   input  logic               ignore_fcs,
   input  logic               in_valid,
   input  logic [8*BYTES-1:0] in_data,
   input  logic [NB_W-1:0]    in_nbytes,
   input  logic               in_last,
   output logic               out_valid,
   output logic [8*BYTES-1:0] out_data,
   output logic [NB_W-1:0]    out_nbytes,
   output logic               out_last,
   output logic               out_user_err,
   output logic               bad_fcs_pulse,
   output logic               stomped_fcs_pulse
);

   if (BYTES < FCS_BYTES) begin : g_bad_width
      $error("rxfcs_check_strip: BYTES must be at least the check sequence size");
   end
   if (KEEP_LEN < FCS_BYTES) begin : g_bad_keep
      $error("rxfcs_check_strip: KEEP_LEN must be at least the check sequence size");
   end

   logic verdict_err;

   rxfcs_crc_check #(.BYTES(BYTES), .NB_W(NB_W)) u_crc (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_data     (in_data),
      .in_nb       (in_nbytes),
      .in_last     (in_last),
      .verdict_err (verdict_err),
      .bad_pulse   (bad_fcs_pulse),
      .stomp_pulse (stomped_fcs_pulse)
   );

   rxfcs_realign #(.BYTES(BYTES), .NB_W(NB_W), .KEEP_LEN(KEEP_LEN)) u_align (
      .clk       (clk),
      .rst_n     (rst_n),
      .strip_en  (strip_en),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_nb     (in_nbytes),
      .in_last   (in_last),
      .in_err    (verdict_err && !ignore_fcs),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_nb    (out_nbytes),
      .out_last  (out_last),
      .out_err   (out_user_err)
   );

   assert_ignore_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ignore_fcs && out_valid) |-> !out_user_err);

endmodule

// File: tb/rxfcs_check_strip_bench.sv
module rxfcs_check_strip_bench;

   localparam int BYTES = 8;
   localparam int NB_W  = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic               rst_n = 1'b0, strip_en = 1'b0, ignore_fcs = 1'b0;
   logic               in_valid = 1'b0, in_last = 1'b0;
   logic [8*BYTES-1:0] in_data = '0;
   logic [NB_W-1:0]    in_nbytes = '0;
   logic               out_valid, out_last, out_user_err, bad_fcs_pulse, stomped_fcs_pulse;
   logic [8*BYTES-1:0] out_data;
   logic [NB_W-1:0]    out_nbytes;

   rxfcs_check_strip u_rxfcs_check_strip (.*);

   int checks = 0, fails = 0, cyc = 0;
   always @(posedge clk) cyc++;

   logic [7:0] obytes[$];
   logic [7:0] frm[$];
   int o_last_n, o_err_n, o_err_off, o_partial, o_dirty, bad_n, stomp_n, bad_adj, last_bad;

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            for (int l = 0; l < BYTES; l++) begin
               if (l < int'(out_nbytes)) obytes.push_back(out_data[8*l +: 8]);
               else if (out_data[8*l +: 8] != 8'h00) o_dirty++;
            end
            if (out_last) o_last_n++;
            if (!out_last && int'(out_nbytes) != BYTES) o_partial++;
            if (out_user_err) begin
               if (out_last) o_err_n++;
               else o_err_off++;
            end
         end
         if (bad_fcs_pulse) begin
            if (last_bad == cyc - 1) bad_adj++;
            last_bad = cyc;
            bad_n++;
         end
         if (stomped_fcs_pulse) stomp_n++;
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] sw_crc(int n);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < n; i++) begin
         c = c ^ {24'h0, frm[i]};
         for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
      return c;
   endfunction

   task automatic clear_mon();
      obytes.delete();
      o_last_n = 0; o_err_n = 0; o_err_off = 0; o_partial = 0; o_dirty = 0;
      bad_n = 0; stomp_n = 0; bad_adj = 0; last_bad = -10;
   endtask

   task automatic do_reset(logic s, logic ig);
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0;
      strip_en = s; ignore_fcs = ig;
      repeat (3) @(negedge clk);
      chk("R9", "out_valid in reset", int'(out_valid), 0);
      chk("R9", "pulses in reset", int'(bad_fcs_pulse | stomped_fcs_pulse | out_user_err), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", "out_valid after reset", int'(out_valid | out_last), 0);
   endtask

   // kind: 0 good, 1 corrupted payload, 2 stomped check sequence
   task automatic build(int len, int kind);
      logic [31:0] c, fcs;
      frm.delete();
      for (int i = 0; i < len - 4; i++) frm.push_back(8'((i * 7 + len) & 8'hFF));
      c = sw_crc(len - 4);
      fcs = (kind == 2) ? c : ~c;
      for (int k = 0; k < 4; k++) frm.push_back(fcs[8*k +: 8]);
      if (kind == 1) frm[0] = frm[0] ^ 8'h10;
   endtask

   task automatic drive_beats(int len, int first, bit gaps);
      int nbeats = (len + BYTES - 1) / BYTES;
      for (int b = 0; b < nbeats; b++) begin
         int nb = (b == nbeats - 1) ? len - b * BYTES : BYTES;
         @(negedge clk);
         in_valid = 1'b1;
         in_last = (b == nbeats - 1);
         in_nbytes = NB_W'(nb);
         in_data = '0;
         for (int l = 0; l < nb; l++) in_data[8*l +: 8] = frm[first + b * BYTES + l];
         if (gaps && (b % 2 == 1) && (b != nbeats - 1)) begin
            @(negedge clk);
            in_valid = 1'b0;
         end
      end
   endtask

   task automatic run_frame(string req, int len, int kind, bit gaps);
      int exp_len, mism, n;
      clear_mon();
      build(len, kind);
      drive_beats(len, 0, gaps);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      repeat (5) @(negedge clk);
      exp_len = (strip_en && len > 8) ? len - 4 : len;
      chk(req, $sformatf("len %0d bytes out", len), obytes.size(), exp_len);
      mism = 0;
      n = (obytes.size() < exp_len) ? obytes.size() : exp_len;
      for (int i = 0; i < n; i++) if (obytes[i] != frm[i]) mism++;
      chk(req, $sformatf("len %0d byte mismatches", len), mism, 0);
      chk(req, "closing beats", o_last_n, 1);
      chk("R5", "err on closing beat", o_err_n, (kind != 0 && !ignore_fcs) ? 1 : 0);
      chk("R5", "err on other beats", o_err_off, 0);
      chk("R10", "short mid beats / dirty lanes", o_partial + o_dirty, 0);
      chk("R7", "bad pulses", bad_n, (kind == 1) ? 1 : 0);
      chk("R7", "stomped pulses", stomp_n, (kind == 2) ? 1 : 0);
   endtask

   task automatic test_good_strip();
      do_reset(1'b1, 1'b0);
      run_frame("R1", 64, 0, 1'b0);
      run_frame("R2", 65, 0, 1'b0);
      run_frame("R2", 66, 0, 1'b0);
      run_frame("R2", 67, 0, 1'b0);
      run_frame("R2", 68, 0, 1'b0);
      run_frame("R2", 69, 0, 1'b0);
      run_frame("R2", 72, 0, 1'b0);
      run_frame("R2", 9, 0, 1'b0);
      run_frame("R2", 1518, 0, 1'b0);
      run_frame("R4", 8, 0, 1'b0);
      run_frame("R4", 5, 0, 1'b0);
      run_frame("R11", 100, 0, 1'b1);
   endtask

   task automatic test_errors_strip();
      do_reset(1'b1, 1'b0);
      run_frame("R5", 100, 1, 1'b0);
      run_frame("R7", 70, 2, 1'b0);
      run_frame("R11", 131, 1, 1'b1);
   endtask

   task automatic test_passthrough();
      do_reset(1'b0, 1'b0);
      run_frame("R3", 64, 0, 1'b0);
      run_frame("R3", 66, 1, 1'b0);
      run_frame("R3", 7, 0, 1'b0);
      run_frame("R3", 1518, 0, 1'b1);
   endtask

   task automatic test_ignore();
      do_reset(1'b1, 1'b1);
      run_frame("R6", 80, 1, 1'b0);
      run_frame("R6", 71, 2, 1'b0);
   endtask

   task automatic test_back_to_back();
      logic [7:0] all[$];
      do_reset(1'b0, 1'b0);
      clear_mon();
      build(8, 1); all = frm;
      build(8, 1); all = {all, frm};
      build(6, 2); all = {all, frm};
      frm = all;
      drive_beats(8, 0, 1'b0);
      drive_beats(8, 8, 1'b0);
      drive_beats(6, 16, 1'b0);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      repeat (5) @(negedge clk);
      chk("R8", "bad pulses", bad_n, 2);
      chk("R8", "adjacent bad pulses", bad_adj, 1);
      chk("R8", "stomped pulses", stomp_n, 1);
      chk("R8", "bytes out", obytes.size(), 22);
      chk("R8", "closing beats", o_last_n, 3);
      chk("R5", "error beats", o_err_n, 3);
   endtask

   initial begin
      test_good_strip();
      test_errors_strip();
      test_passthrough();
      test_ignore();
      test_back_to_back();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule